// File: doc/BRIEF.md
# LIN Host Header Generator

This block sends the header of a LIN frame on a single serial transmit line. When the host pulses the start strobe, the block holds the line low for a break field whose length is picked by a 2-bit code. It then leaves the line high for a coded gap and sends the sync byte as an ordinary 8N1 character. After a second gap it sends a protected identifier byte in the same character format. The host supplies that byte with the start strobe.

All timing is counted in ticks of a one-cycle bit-rate enable that comes from outside. The block holds `busy` high while a header is in progress. It pulses `done` for one clock when the identifier's stop bit ends. The two gaps share one select code. The gap between the sync and identifier fields stops growing at four bit times, while the gap between the break and the sync field keeps growing with the code. The start strobe acts as the automatic-transmit command, so a pulse on it is all that is needed to run a header. The block itself does nothing else.

Top module: `lin_hdr_tx`

## Requirements
- R1: The break field drives the line low for 13, 17, 21 or 26 bit times for break code (`brkSel`) 0, 1, 2 or 3.
- R2: The gap after the break, before the sync start bit, lasts 1, 4, 8 or 14 bit times for gap code (`gapSel`) 0, 1, 2 or 3.
- R3: The gap after the sync stop bit, before the identifier start bit, lasts 1 bit time for gap code 0 and 4 bit times for gap codes 1, 2 and 3.
- R4: The sync field is the byte 0x55, sent as a low start bit, 8 data bits least significant first, and one high stop bit (10 bit times).
- R5: The identifier field is the `pid` byte, sent in the same 10-bit format. The header order is always break, gap, sync, gap, identifier.
- R6: `brkSel`, `gapSel` and `pid` are sampled in the cycle the start strobe is accepted. A start strobe while `busy` is high is ignored and changes neither the header in progress nor the state after it.
- R7: The line is high while idle and throughout both gaps.
- R8: Time advances only on `bitTick` pulses. While busy, the line does not change in a cycle that has no tick.
- R9: `busy` rises on the clock edge that accepts a start and falls on the edge that ends the identifier's stop bit. `done` is high for exactly that one following cycle, and only with `busy` low.
- R10: While reset is asserted and just after it, the line is high and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle bit-rate enable |
| startReq | input | 1 | Start-of-header strobe |
| brkSel | input | 2 | Break length code |
| gapSel | input | 2 | Inter-field gap code |
| pid | input | 8 | Protected identifier byte |
| txLine | output | 1 | Serial transmit line |
| busy | output | 1 | Header in progress |
| done | output | 1 | One-cycle end-of-header pulse |

## Verification
The hardest cases to reach are a start strobe with new selects that lands in the middle of a header, and a long stretch with no ticks while the line sits in the middle of a field. The bench walks a table that covers every break and gap code and records the line value at each tick. On two runs it changes the selects and identifier and pulses start partway through the header. On one run it stops the tick source for about thirty cycles. In each case the recorded header must still match the one built from the values sampled at the accepted start.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

  localparam int CNT_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BREAK, ST_GAP1, ST_SYNC, ST_GAP2, ST_PID
  } hdrState_e;

  typedef enum logic [1:0] {
    LINE_IDLE, LINE_LOW, LINE_DATA
  } lineSel_e;

  typedef struct packed {
    logic     capture;
    logic     loadSync;
    logic     loadPid;
    logic     shift;
    lineSel_e lineSel;
  } dpCtl_t;

  function automatic logic [CNT_W-1:0] breakTicks(input logic [1:0] code);
    case (code)
      2'd0:    breakTicks = CNT_W'(13);
      2'd1:    breakTicks = CNT_W'(17);
      2'd2:    breakTicks = CNT_W'(21);
      default: breakTicks = CNT_W'(26);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] gapOneTicks(input logic [1:0] code);
    case (code)
      2'd0:    gapOneTicks = CNT_W'(1);
      2'd1:    gapOneTicks = CNT_W'(4);
      2'd2:    gapOneTicks = CNT_W'(8);
      default: gapOneTicks = CNT_W'(14);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] gapTwoTicks(input logic [1:0] code);
    gapTwoTicks = (code == 2'd0) ? CNT_W'(1) : CNT_W'(4);
  endfunction

endpackage

// File: rtl/lin_hdr_ctrl.sv
module lin_hdr_ctrl
  import lin_hdr_pkg::*;
#(
  parameter int FRAME_BITS = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       startReq,
  input  logic [1:0] brkSel,
  input  logic [1:0] gapSel,
  output dpCtl_t     ctl,
  output logic       busy,
  output logic       done
);

  hdrState_e        state, stateNext;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] segLen;
  logic [1:0]       brkQ, gapQ;
  logic             lastTick;

  always_comb begin
    case (state)
      ST_BREAK: segLen = breakTicks(brkQ);
      ST_GAP1:  segLen = gapOneTicks(gapQ);
      ST_GAP2:  segLen = gapTwoTicks(gapQ);
      ST_SYNC,
      ST_PID:   segLen = CNT_W'(FRAME_BITS);
      default:  segLen = CNT_W'(1);
    endcase
  end

  assign busy     = (state != ST_IDLE);
  assign lastTick = busy && bitTick && (cnt == segLen - CNT_W'(1));

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (startReq) stateNext = ST_BREAK;
      ST_BREAK: if (lastTick) stateNext = ST_GAP1;
      ST_GAP1:  if (lastTick) stateNext = ST_SYNC;
      ST_SYNC:  if (lastTick) stateNext = ST_GAP2;
      ST_GAP2:  if (lastTick) stateNext = ST_PID;
      ST_PID:   if (lastTick) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.capture  = (state == ST_IDLE) && startReq;
    ctl.loadSync = (state == ST_GAP1) && lastTick;
    ctl.loadPid  = (state == ST_GAP2) && lastTick;
    ctl.shift    = ((state == ST_SYNC) || (state == ST_PID)) && bitTick && !lastTick;
    case (state)
      ST_BREAK:       ctl.lineSel = LINE_LOW;
      ST_SYNC, ST_PID: ctl.lineSel = LINE_DATA;
      default:        ctl.lineSel = LINE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      brkQ  <= '0;
      gapQ  <= '0;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_PID) && lastTick;
      if (ctl.capture) begin
        brkQ <= brkSel;
        gapQ <= gapSel;
        cnt  <= '0;
      end else if (lastTick) begin
        cnt <= '0;
      end else if (busy && bitTick) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/lin_hdr_dp.sv
module lin_hdr_dp
  import lin_hdr_pkg::*;
#(
  parameter int              DATA_BITS = 8,
  parameter logic [7:0]      SYNC_BYTE = 8'h55
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               ctl,
  input  logic [DATA_BITS-1:0] pid,
  output logic                 txLine
);

  localparam int SR_W = DATA_BITS + 2;

  logic [SR_W-1:0]      shiftReg;
  logic [DATA_BITS-1:0] pidQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '1;
      pidQ     <= '0;
    end else begin
      if (ctl.capture) pidQ <= pid;
      if (ctl.loadSync)      shiftReg <= {1'b1, SYNC_BYTE[DATA_BITS-1:0], 1'b0};
      else if (ctl.loadPid)  shiftReg <= {1'b1, pidQ, 1'b0};
      else if (ctl.shift)    shiftReg <= {1'b1, shiftReg[SR_W-1:1]};
    end
  end

  always_comb begin
    case (ctl.lineSel)
      LINE_LOW:  txLine = 1'b0;
      LINE_DATA: txLine = shiftReg[0];
      default:   txLine = 1'b1;
    endcase
  end

endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx
  import lin_hdr_pkg::*;
#(
  parameter int         DATA_BITS = 8,
  parameter logic [7:0] SYNC_BYTE = 8'h55
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitTick,
  input  logic                 startReq,
  input  logic [1:0]           brkSel,
  input  logic [1:0]           gapSel,
  input  logic [DATA_BITS-1:0] pid,
  output logic                 txLine,
  output logic                 busy,
  output logic                 done
);

  localparam int FRAME_BITS = DATA_BITS + 2;

  dpCtl_t ctl;

  lin_hdr_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitTick  (bitTick),
    .startReq (startReq),
    .brkSel   (brkSel),
    .gapSel   (gapSel),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done)
  );

  lin_hdr_dp #(.DATA_BITS(DATA_BITS), .SYNC_BYTE(SYNC_BYTE)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .pid    (pid),
    .txLine (txLine)
  );

endmodule

// File: rtl/lin_hdr_chk.sv
module lin_hdr_chk (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic busy,
  input logic done,
  input logic txLine
);

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);  // R7

  AST_BREAK_STARTS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !txLine);  // R1

  AST_NO_TICK_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !bitTick) |=> $stable(txLine));  // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R9

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);  // R9

  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);  // R9

endmodule

bind lin_hdr_tx lin_hdr_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .bitTick (bitTick),
  .busy    (busy),
  .done    (done),
  .txLine  (txLine)
);

// File: tb/sim_lin_hdr_tx.sv
module sim_lin_hdr_tx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b0;
  logic       startReq = 1'b0;
  logic [1:0] brkSel = '0;
  logic [1:0] gapSel = '0;
  logic [7:0] pid = '0;
  logic       txLine, busy, done;
  logic       tickEn = 1'b1;
  int         div = 0;
  int         checks = 0;
  int         fails = 0;

  always #2.5 clk = ~clk;

  lin_hdr_tx u0 (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .startReq(startReq),
    .brkSel(brkSel), .gapSel(gapSel), .pid(pid),
    .txLine(txLine), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    div     <= (div == 2) ? 0 : div + 1;
    bitTick <= tickEn && (div == 2);
  end

  // table entries: {brkSel, gapSel, pid}
  localparam logic [11:0] VEC [8] = '{
    {2'd0, 2'd0, 8'h3C}, {2'd1, 2'd1, 8'hA5}, {2'd2, 2'd2, 8'h01},
    {2'd3, 2'd3, 8'hFE}, {2'd0, 2'd3, 8'h80}, {2'd3, 2'd0, 8'h7F},
    {2'd1, 2'd2, 8'h00}, {2'd2, 2'd1, 8'hFF}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int segVal(input logic [127:0] b, input int off, input int len);
    int v = 0;
    for (int i = 0; i < len; i++) v |= int'(b[off + i]) << i;
    return v;
  endfunction

  task automatic runFrame(input logic [11:0] v, input int pauseAt, input int intrudeAt);
    int bl, g1, g2, n, total, pauseCyc;
    logic [127:0] got;
    logic [9:0] syncF, pidF;
    logic pLine, paused, intruded;
    bl = (v[11:10] == 0) ? 13 : (v[11:10] == 1) ? 17 : (v[11:10] == 2) ? 21 : 26;
    g1 = (v[9:8] == 0) ? 1 : (v[9:8] == 1) ? 4 : (v[9:8] == 2) ? 8 : 14;
    g2 = (v[9:8] == 0) ? 1 : 4;
    syncF = {1'b1, 8'h55, 1'b0};
    pidF  = {1'b1, v[7:0], 1'b0};
    total = bl + g1 + 10 + g2 + 10;
    got = '1; n = 0; paused = 0; intruded = 0; pauseCyc = 0; pLine = 1'b1;
    @(negedge clk);
    brkSel = v[11:10]; gapSel = v[9:8]; pid = v[7:0]; startReq = 1'b1;
    while (1) begin
      @(negedge clk);
      startReq = 1'b0;
      if (!busy) break;
      if (bitTick) begin
        if (n < 128) got[n] = txLine;
        n++;
      end
      if (n == intrudeAt && !intruded) begin
        intruded = 1; startReq = 1'b1;
        brkSel = ~v[11:10]; gapSel = ~v[9:8]; pid = ~v[7:0];
      end
      if (n == pauseAt && !paused) begin
        paused = 1; tickEn = 1'b0; pauseCyc = 0;
      end
      if (paused && !tickEn) begin
        pauseCyc++;
        if (pauseCyc == 3) pLine = txLine;
        if (pauseCyc == 30) begin
          check(txLine == pLine && busy, "R8 line held without ticks", txLine, pLine);
          tickEn = 1'b1;
        end
      end
    end
    check(n == total, "R5 header length in ticks", n, total);
    check(segVal(got, 0, bl) == 0, "R1 break low", segVal(got, 0, bl), 0);
    check(segVal(got, bl, g1) == (1 << g1) - 1, "R2 first gap", segVal(got, bl, g1), (1 << g1) - 1);
    check(got[bl + g1 - 1] == 1'b1 && got[bl + g1] == 1'b0, "R7 first gap edge", got[bl + g1], 0);
    check(segVal(got, bl + g1, 10) == int'(syncF), "R4 sync field", segVal(got, bl + g1, 10), syncF);
    check(segVal(got, bl + g1 + 10, g2) == (1 << g2) - 1 && got[bl + g1 + 10 + g2] == 1'b0,
          "R3 second gap", segVal(got, bl + g1 + 10, g2), (1 << g2) - 1);
    check(segVal(got, bl + g1 + 10 + g2, 10) == int'(pidF), "R5 identifier field",
          segVal(got, bl + g1 + 10 + g2, 10), pidF);
    check(done == 1'b1 && txLine == 1'b1, "R9 done at end", done, 1);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R9 done one cycle", done, 0);
    if (intrudeAt >= 0) begin
      repeat (20) @(negedge clk);
      check(busy == 1'b0 && txLine == 1'b1, "R6 late start ignored", busy, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R10: reset state, with a start pulse during reset
    repeat (2) @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    check(txLine == 1'b1, "R10 line high in reset", txLine, 1);
    check(busy == 1'b0 && done == 1'b0, "R10 idle in reset", busy, 0);
    startReq = 1'b0;
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && txLine == 1'b1, "R10 idle after reset", busy, 0);

    for (int i = 0; i < 8; i++) runFrame(VEC[i], -1, -1);

    // R6: start with new values mid-break and mid-identifier
    runFrame({2'd2, 2'd1, 8'h96}, -1, 5);
    runFrame({2'd0, 2'd2, 8'h4B}, -1, 40);
    // R8: tick source stopped mid-sync
    runFrame({2'd1, 2'd3, 8'hC3}, 40, -1);
    // R7: idle between headers
    repeat (10) @(negedge clk);
    check(txLine == 1'b1 && busy == 1'b0, "R7 idle line high", txLine, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule